// File: doc/BRIEF.md
# Dual-Preset Programmable Pulse-Width Generator

This block turns a fast system clock into a square wave whose high time and low time are programmed separately. Two 8-bit preset inputs, one per level, set how long each level lasts. A single up-counter times whichever phase is running. When it reaches its all-ones value, it loads the preset that belongs to the next phase instead of incrementing, and the output level flips. A preset of P therefore yields a phase of 256 - P clock cycles, so a smaller preset gives a longer phase.

Everything runs on the one input clock. The level register is updated through a clock enable driven by the counter's terminal-count condition; no derived signal is ever used as a clock. A phase-end strobe marks the final cycle of every phase. Callers can use it to change presets in step with the waveform, or to count periods.

Typical use is tone or PWM generation with a programmable duty cycle. Software or a neighbouring block drives the two presets. Each preset is captured only when its own phase begins.

Top module: `pwg_dual_preset`

## Requirements
- R1: Each high phase of `wave_o` lasts exactly 256 - H clock cycles, where H is the value on `hi_preset` at the clock edge on which the high phase begins.
- R2: Each low phase of `wave_o` lasts exactly 256 - L clock cycles, where L is the value on `lo_preset` at the clock edge on which the low phase begins.
- R3: The phase timer counts up by one per clock. When it holds 0xFF, the next edge loads the preset of the starting phase instead of wrapping. Run lengths are the observable result: consecutive phases with random presets all match 256 minus their preset.
- R4: A preset of 0xFF gives a phase of exactly one cycle, and a preset of 0x00 gives a phase of 256 cycles. With both presets at 0xFF, the output alternates level every cycle.
- R5: `wave_o` changes level only on the edge that follows a cycle in which `phase_end_o` is 1. `phase_end_o` is 1 on the last cycle of each phase and 0 on every other cycle of that phase.
- R6: A preset change made in the middle of a phase does not alter the running phase. It takes effect at the next phase of that level.
- R7: While the synchronous reset `rst` is high, `wave_o` is 0, and `phase_end_o` is 0 unless `lo_preset` is 0xFF. The first low phase after reset is released lasts 256 - L cycles, where L is the `lo_preset` value at the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hi_preset | input | 8 | Preset for the high phase; length = 256 - value |
| lo_preset | input | 8 | Preset for the low phase; length = 256 - value |
| wave_o | output | 1 | Generated square wave |
| phase_end_o | output | 1 | High on the final cycle of each phase |

## Verification
A corrupted counter value, such as a skipped increment, a wrong wrap value or the wrong preset being loaded, shows up as a phase whose length differs from 256 minus its preset. It is therefore visible at `wave_o` no later than the end of the phase in which the corruption occurs, at most 256 cycles later. A fault in the level register or in the phase selection shows within a single phase as a missed or extra toggle. It can also appear as a strobe that disagrees with the edge that follows it. The bench measures every run length against the preset captured when that run began, and it checks the strobe on every cycle.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

endpackage

// File: rtl/pwg_count.sv
module pwg_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    assign wrap_o = (state_q.cnt == TOP);
    assign cnt_o  = state_q.cnt;

    always_comb begin
        state_d = state_q;
        if (rst || wrap_o) begin
            state_d.cnt = load_val;
        end else begin
            state_d.cnt = state_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // R3: terminal count reloads the presented preset
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_o == $past(load_val)));

    // R3: below terminal count the timer advances by exactly one
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> (cnt_o == $past(cnt_o) + ONE));

endmodule

// File: rtl/pwg_level.sv
module pwg_level #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    output logic         level_o,
    output logic [W-1:0] next_o
);

    import pwg_pkg::*;

    typedef struct packed {
        level_e lvl;
    } lvl_state_t;

    lvl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.lvl = LVL_LOW;
        end else if (adv_i) begin
            state_d.lvl = (state_q.lvl == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
        end
    end

    always_comb begin
        if (rst) begin
            next_o = lo_i;
        end else if (state_q.lvl == LVL_HIGH) begin
            next_o = lo_i;
        end else begin
            next_o = hi_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign level_o = state_q.lvl;

    // R5: the level flips on each phase end
    a_r5_toggle: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> (level_o != $past(level_o)));

    // R5: the level holds between phase ends
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(level_o));

endmodule

// File: rtl/pwg_dual_preset.sv
module pwg_dual_preset #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hi_preset,
    input  logic [W-1:0] lo_preset,
    output logic         wave_o,
    output logic         phase_end_o
);

    logic [W-1:0] cnt_w;
    logic         wrap_w;
    logic [W-1:0] next_w;
    logic         level_w;

    pwg_count #(.W(W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load_val (next_w),
        .cnt_o    (cnt_w),
        .wrap_o   (wrap_w)
    );

    pwg_level #(.W(W)) u_level (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (wrap_w),
        .hi_i    (hi_preset),
        .lo_i    (lo_preset),
        .level_o (level_w),
        .next_o  (next_w)
    );

    assign wave_o      = level_w;
    assign phase_end_o = wrap_w;

    // R1: a newly started high phase holds the high preset
    a_r1_high_load: assert property (@(posedge clk) disable iff (rst)
        (phase_end_o && !wave_o) |=> (wave_o && cnt_w == $past(hi_preset)));

    // R2: a newly started low phase holds the low preset
    a_r2_low_load: assert property (@(posedge clk) disable iff (rst)
        (phase_end_o && wave_o) |=> (!wave_o && cnt_w == $past(lo_preset)));

endmodule

// File: tb/tb_pwg_dual_preset.sv
`timescale 1ns/1ps
module tb_pwg_dual_preset;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] hi  = 8'h10;
    logic [7:0] lo  = 8'h80;
    logic       wave;
    logic       strobe;

    always #2.5 clk = ~clk;

    pwg_dual_preset #(.W(8)) dut (
        .clk         (clk),
        .rst         (rst),
        .hi_preset   (hi),
        .lo_preset   (lo),
        .wave_o      (wave),
        .phase_end_o (strobe)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    phase_cnt = 0;
    int    cyc = 0;
    int    run = 0;
    int    exp_len = 0;
    logic  prev_w = 1'b0;
    logic  prev_s = 1'b0;
    bit    done = 1'b0;
    string tag = "R7";

    function automatic int phase_len(logic [7:0] p);
        return 256 - int'(p);
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: samples at the falling edge, before stimulus moves.
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            chk(wave == 1'b0, "R7 wave low during reset", int'(wave), 0);
            if (lo != 8'hFF)
                chk(strobe == 1'b0, "R7 strobe low during reset", int'(strobe), 0);
            run     = 1;
            exp_len = phase_len(lo);
            prev_w  = 1'b0;
            prev_s  = strobe;
        end else begin
            if (wave == prev_w) begin
                run++;
                chk(prev_s == 1'b0, {"R5 strobe before non-end cycle ", tag},
                    int'(prev_s), 0);
            end else begin
                chk(run == exp_len,
                    $sformatf("%s %s run length", prev_w ? "R1" : "R2", tag),
                    run, exp_len);
                chk(prev_s == 1'b1, {"R5 strobe on last cycle ", tag},
                    int'(prev_s), 1);
                run     = 1;
                exp_len = phase_len(wave ? hi : lo);
                phase_cnt++;
            end
            prev_w = wave;
            prev_s = strobe;
        end
        if (cyc > 150000 && !done) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_phases(int n);
        int target;
        target = phase_cnt + n;
        while (phase_cnt < target) @(negedge clk);
        #1;
    endtask

    task automatic wait_level(logic lvl);
        @(negedge clk);
        while (!(wave == lvl && run == 1)) @(negedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(4);
        // R7: release reset; first low phase uses lo = 0x80
        rst = 1'b0;
        tag = "R7";
        wait_phases(1);
        tag = "R3";
        wait_phases(3);

        // R4: corner presets
        tag = "R4";
        hi = 8'hFF; lo = 8'h00;
        wait_phases(5);
        hi = 8'h00; lo = 8'hFF;
        wait_phases(5);
        hi = 8'hFF; lo = 8'hFF;
        wait_phases(10);
        hi = 8'h00; lo = 8'h00;
        wait_phases(4);

        // R1 R2 R3: random preset pairs
        tag = "R3 random";
        for (int i = 0; i < 12; i++) begin
            hi = 8'($urandom);
            lo = 8'($urandom);
            wait_phases(4);
        end

        // R6: change presets a few cycles into a high phase
        tag = "R6";
        hi = 8'h40; lo = 8'hC0;
        wait_phases(3);
        wait_level(1'b1);
        step(5);
        hi = 8'hF0; lo = 8'h20;
        wait_phases(4);
        wait_level(1'b0);
        step(7);
        hi = 8'h08; lo = 8'hE8;
        wait_phases(4);

        // R7: reset in mid-phase, then restart
        tag = "R7 mid";
        hi = 8'h30; lo = 8'h90;
        wait_level(1'b1);
        step(10);
        rst = 1'b1;
        step(3);
        lo = 8'hA0;
        step(1);
        rst = 1'b0;
        wait_phases(1);
        tag = "R3";
        wait_phases(3);

        finish_run();
    end

endmodule